// File: doc/BRIEF.md
# NAND Flash Page Read Sequencer

This block reads part of one page from an 8-bit NAND flash device that shares one byte-wide bus for commands, addresses and data. A host hands over a starting column, a row (block and page) and a byte count through a request/acknowledge pair. The sequencer then writes the read-setup command, the address bytes and the read-confirm command to the device. Each of these writes is framed by the command-latch or address-latch strobe and latched by a rising write-enable edge.

Once the confirm command has been written, the sequencer lets a guard interval pass and then waits on the device's ready/busy line, which goes low while the cell array loads the page register. A timeout counter gives up if the line stays low too long. When the device is ready, the sequencer pulses read-enable once per byte. It captures each byte near the end of the low phase and hands it to the host on a valid/ready stream that may stall.

After the last byte has been accepted, chip-enable is released and a one-cycle done pulse is given. Every setup, pulse width and hold time is a parameter counted in system clock cycles. Requests that would run past the end of the page are refused before any bus activity starts.

Top module: `nand_page_reader`

## Requirements
- R1: While reset is asserted and after it, chip-enable, write-enable and read-enable are high, both latch strobes are low, the bus driver enable is low, outValid is low and reqAck is high.
- R2: The first bus write of a read carries byte 0x00 with the command strobe high and the address strobe low at the rising write-enable edge.
- R3: Exactly five address writes follow, with the address strobe high and the command strobe low. Their order is column[7:0], column[12:8] (upper bits zero), row[7:0], row[15:8], row[17:16] (upper bits zero).
- R4: The last bus write carries byte 0x30 with the command strobe high and the address strobe low.
- R5: Read-enable is never driven low while the device's ready/busy line is low after the confirm write.
- R6: Exactly reqLen read-enable pulses are issued, and the bytes reach outData in column order starting at reqCol.
- R7: While outValid is high and outReady is low, outValid stays high and outData holds its value; no byte is dropped or repeated.
- R8: One cycle after the last byte is accepted, done is high for exactly one cycle, chip-enable is high and the bus driver is off.
- R9: If ready/busy stays low for BUSY_LIMIT clock cycles, busyErr pulses for one cycle, chip-enable goes high, no read-enable pulse is issued and the block returns to idle.
- R10: A request with reqLen of zero or with reqCol plus reqLen above 4352 is acknowledged, gives a one-cycle rangeErr pulse and causes no bus activity (chip-enable stays high, no write-enable edge).
- R11: During every write-enable low phase, the bus byte and both latch strobes stay constant, and write-enable and read-enable are never low together.
- R12: reqAck is high only while idle; an accepted valid request pulls chip-enable low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host read request |
| reqAck | output | 1 | Request taken (high when idle) |
| reqCol | input | 13 | Starting column in the page |
| reqRow | input | 18 | Row address (block and page) |
| reqLen | input | 13 | Number of bytes to read |
| outData | output | 8 | Read byte |
| outValid | output | 1 | outData holds a byte |
| outReady | input | 1 | Host accepts the byte |
| done | output | 1 | One-cycle pulse after the last byte |
| rangeErr | output | 1 | One-cycle pulse for a refused request |
| busyErr | output | 1 | One-cycle pulse for a ready/busy timeout |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch strobe |
| nandAle | output | 1 | Address latch strobe |
| nandWeN | output | 1 | Write enable, active low |
| nandReN | output | 1 | Read enable, active low |
| nandIoOut | output | 8 | Byte driven onto the flash bus |
| nandIoOe | output | 1 | Bus driver enable |
| nandIoIn | input | 8 | Byte read from the flash bus |
| nandRdy | input | 1 | Ready/busy line, high when ready |

## Verification
A behavioural flash model records every latched command and address byte and serves page bytes from a column-dependent pattern. Short reads from column zero with the host always ready check the bus sequence and address packing. A read ending exactly at the last column, with a row that has every bit set, exercises the top address bits and the range boundary. A long read under pseudo-random host stalls separates correct holding of a byte from loss or duplication. Refused requests, a stuck busy line, and a clean read that follows the timeout show whether rejection and recovery leave the bus untouched.

// File: rtl/nandrd_pkg.sv
package nandrd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WLOW,
    ST_WHOLD,
    ST_WAITWB,
    ST_BUSY,
    ST_WAITRR,
    ST_RELOW,
    ST_REHIGH,
    ST_PUSH,
    ST_FINISH
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;     // latch request fields
    logic       capture;  // sample bus byte
    logic       advance;  // byte accepted by host
    logic [2:0] cycSel;   // which bus write is in progress
  } dpCtl_t;

  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] CMD_CONFIRM = 8'h30;

endpackage

// File: rtl/nandrd_dpath.sv
module nandrd_dpath
  import nandrd_pkg::*;
#(
  parameter int COL_W      = 13,
  parameter int ROW_W      = 18,
  parameter int LEN_W      = 13,
  parameter int PAGE_BYTES = 4352
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           dpCtl,
  input  logic [COL_W-1:0] reqCol,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       nandIoIn,
  output logic             rangeBad,
  output logic             lastByte,
  output logic [7:0]       ioOut,
  output logic [7:0]       outData
);

  localparam int COL_CYC   = (COL_W + 7) / 8;
  localparam int ROW_CYC   = (ROW_W + 7) / 8;
  localparam int ADDR_CYC  = COL_CYC + ROW_CYC;
  localparam int COL_PAD   = 8 * COL_CYC;
  localparam int ROW_PAD   = 8 * ROW_CYC;
  localparam int ADDR_BITS = COL_PAD + ROW_PAD;
  localparam logic [2:0] LAST_SEL = 3'(ADDR_CYC + 1);

  logic [COL_W-1:0]     colQ;
  logic [ROW_W-1:0]     rowQ;
  logic [LEN_W-1:0]     remQ;
  logic [7:0]           dataQ;
  logic [ADDR_BITS-1:0] addrVec;
  logic [7:0]           addrByte [ADDR_CYC];

  assign rangeBad = (reqLen == '0) ||
                    ((32'(reqCol) + 32'(reqLen)) > 32'(PAGE_BYTES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colQ  <= '0;
      rowQ  <= '0;
      remQ  <= '0;
      dataQ <= '0;
    end else begin
      if (dpCtl.load) begin
        colQ <= reqCol;
        rowQ <= reqRow;
        remQ <= reqLen;
      end else if (dpCtl.advance) begin
        remQ <= remQ - 1'b1;
      end
      if (dpCtl.capture) dataQ <= nandIoIn;
    end
  end

  assign lastByte = (remQ == LEN_W'(1));
  assign outData  = dataQ;

  // column bytes first, then row bytes, least significant byte first
  assign addrVec = {ROW_PAD'(rowQ), COL_PAD'(colQ)};

  for (genvar g = 0; g < ADDR_CYC; g++) begin : gAddrByte
    assign addrByte[g] = addrVec[8*g +: 8];
  end

  always_comb begin
    ioOut = CMD_READ;
    if (dpCtl.cycSel == LAST_SEL) ioOut = CMD_CONFIRM;
    for (int k = 0; k < ADDR_CYC; k++) begin
      if (dpCtl.cycSel == 3'(k + 1)) ioOut = addrByte[k];
    end
  end

endmodule

// File: rtl/nandrd_ctrl.sv
module nandrd_ctrl
  import nandrd_pkg::*;
#(
  parameter int ADDR_CYC   = 5,
  parameter int T_SETUP    = 2,
  parameter int T_WE_LOW   = 3,
  parameter int T_WE_HIGH  = 2,
  parameter int T_WB       = 5,
  parameter int T_RR       = 2,
  parameter int T_RE_LOW   = 3,
  parameter int T_RE_HIGH  = 2,
  parameter int BUSY_LIMIT = 2000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   rangeBad,
  input  logic   lastByte,
  input  logic   outReady,
  input  logic   nandRdy,
  output logic   reqAck,
  output dpCtl_t dpCtl,
  output logic   outValid,
  output logic   done,
  output logic   rangeErr,
  output logic   busyErr,
  output logic   nandCeN,
  output logic   nandCle,
  output logic   nandAle,
  output logic   nandWeN,
  output logic   nandReN,
  output logic   nandIoOe
);

  localparam int M1 = (T_SETUP > T_WE_LOW) ? T_SETUP : T_WE_LOW;
  localparam int M2 = (T_WE_HIGH > T_WB) ? T_WE_HIGH : T_WB;
  localparam int M3 = (T_RR > T_RE_LOW) ? T_RR : T_RE_LOW;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int M5 = (M3 > T_RE_HIGH) ? M3 : T_RE_HIGH;
  localparam int TMR_MAX = (M4 > M5) ? M4 : M5;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int BUSY_W  = $clog2(BUSY_LIMIT + 1);
  localparam logic [2:0] LAST_IDX = 3'(ADDR_CYC + 1);

  rdState_t           state, stateNext;
  logic [TMR_W-1:0]   tmr;
  logic [BUSY_W-1:0]  busyCnt;
  logic [2:0]         cycIdx;
  logic [1:0]         rdySync;
  logic               tmrDone, accept, timedOut, inWrite, isCmd;

  function automatic logic [TMR_W-1:0] loadFor(rdState_t s);
    case (s)
      ST_WSETUP: return TMR_W'(T_SETUP - 1);
      ST_WLOW:   return TMR_W'(T_WE_LOW - 1);
      ST_WHOLD:  return TMR_W'(T_WE_HIGH - 1);
      ST_WAITWB: return TMR_W'(T_WB - 1);
      ST_WAITRR: return TMR_W'(T_RR - 1);
      ST_RELOW:  return TMR_W'(T_RE_LOW - 1);
      ST_REHIGH: return TMR_W'(T_RE_HIGH - 1);
      default:   return '0;
    endcase
  endfunction

  assign tmrDone  = (tmr == '0);
  assign reqAck   = (state == ST_IDLE);
  assign accept   = reqAck && reqValid;
  assign timedOut = (state == ST_BUSY) && !rdySync[1] &&
                    (busyCnt == BUSY_W'(BUSY_LIMIT - 1));

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (accept && !rangeBad) stateNext = ST_WSETUP;
      ST_WSETUP: if (tmrDone) stateNext = ST_WLOW;
      ST_WLOW:   if (tmrDone) stateNext = ST_WHOLD;
      ST_WHOLD:  if (tmrDone) stateNext = (cycIdx == LAST_IDX) ? ST_WAITWB : ST_WSETUP;
      ST_WAITWB: if (tmrDone) stateNext = ST_BUSY;
      ST_BUSY: begin
        if (rdySync[1])    stateNext = ST_WAITRR;
        else if (timedOut) stateNext = ST_IDLE;
      end
      ST_WAITRR: if (tmrDone) stateNext = ST_RELOW;
      ST_RELOW:  if (tmrDone) stateNext = ST_REHIGH;
      ST_REHIGH: if (tmrDone) stateNext = ST_PUSH;
      ST_PUSH:   if (outReady) stateNext = lastByte ? ST_FINISH : ST_RELOW;
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      busyCnt  <= '0;
      cycIdx   <= '0;
      rdySync  <= '0;
      rangeErr <= 1'b0;
      busyErr  <= 1'b0;
    end else begin
      state    <= stateNext;
      rdySync  <= {rdySync[0], nandRdy};
      rangeErr <= accept && rangeBad;
      busyErr  <= timedOut;
      if (stateNext != state) tmr <= loadFor(stateNext);
      else if (!tmrDone)      tmr <= tmr - 1'b1;
      if (state == ST_BUSY) busyCnt <= busyCnt + 1'b1;
      else                  busyCnt <= '0;
      if (accept)                             cycIdx <= '0;
      else if (state == ST_WHOLD && tmrDone)  cycIdx <= cycIdx + 1'b1;
    end
  end

  assign inWrite = (state == ST_WSETUP) || (state == ST_WLOW) || (state == ST_WHOLD);
  assign isCmd   = (cycIdx == 3'd0) || (cycIdx == LAST_IDX);

  assign nandCeN  = (state == ST_IDLE) || (state == ST_FINISH);
  assign nandCle  = inWrite && isCmd;
  assign nandAle  = inWrite && !isCmd;
  assign nandWeN  = (state != ST_WLOW);
  assign nandReN  = (state != ST_RELOW);
  assign nandIoOe = inWrite;
  assign outValid = (state == ST_PUSH);
  assign done     = (state == ST_FINISH);

  assign dpCtl.load    = accept && !rangeBad;
  assign dpCtl.capture = (state == ST_RELOW) && tmrDone;
  assign dpCtl.advance = (state == ST_PUSH) && outReady;
  assign dpCtl.cycSel  = cycIdx;

  // R9: the wait on ready/busy never outlasts the configured limit
  assert_busy_bounded_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |-> (busyCnt < BUSY_W'(BUSY_LIMIT)));

  // R9: a timeout leaves the device deselected on the next cycle
  assert_timeout_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    timedOut |=> (nandCeN && busyErr));

endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nandrd_pkg::*;
#(
  parameter int COL_W      = 13,
  parameter int ROW_W      = 18,
  parameter int LEN_W      = 13,
  parameter int PAGE_BYTES = 4352,
  parameter int T_SETUP    = 2,
  parameter int T_WE_LOW   = 3,
  parameter int T_WE_HIGH  = 2,
  parameter int T_WB       = 5,
  parameter int T_RR       = 2,
  parameter int T_RE_LOW   = 3,
  parameter int T_RE_HIGH  = 2,
  parameter int BUSY_LIMIT = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqAck,
  input  logic [COL_W-1:0] reqCol,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [LEN_W-1:0] reqLen,
  output logic [7:0]       outData,
  output logic             outValid,
  input  logic             outReady,
  output logic             done,
  output logic             rangeErr,
  output logic             busyErr,
  output logic             nandCeN,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN,
  output logic [7:0]       nandIoOut,
  output logic             nandIoOe,
  input  logic [7:0]       nandIoIn,
  input  logic             nandRdy
);

  localparam int ADDR_CYC = (COL_W + 7) / 8 + (ROW_W + 7) / 8;

  dpCtl_t dpCtl;
  logic   rangeBad, lastByte;

  nandrd_ctrl #(
    .ADDR_CYC(ADDR_CYC), .T_SETUP(T_SETUP), .T_WE_LOW(T_WE_LOW),
    .T_WE_HIGH(T_WE_HIGH), .T_WB(T_WB), .T_RR(T_RR),
    .T_RE_LOW(T_RE_LOW), .T_RE_HIGH(T_RE_HIGH), .BUSY_LIMIT(BUSY_LIMIT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rangeBad(rangeBad),
    .lastByte(lastByte), .outReady(outReady), .nandRdy(nandRdy),
    .reqAck(reqAck), .dpCtl(dpCtl), .outValid(outValid), .done(done),
    .rangeErr(rangeErr), .busyErr(busyErr), .nandCeN(nandCeN),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandIoOe(nandIoOe)
  );

  nandrd_dpath #(
    .COL_W(COL_W), .ROW_W(ROW_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .reqCol(reqCol), .reqRow(reqRow),
    .reqLen(reqLen), .nandIoIn(nandIoIn), .rangeBad(rangeBad),
    .lastByte(lastByte), .ioOut(nandIoOut), .outData(outData)
  );

  // R11: bus byte and latch strobes frozen while write-enable is low
  assert_we_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN && $past(!nandWeN)) |->
      ($stable(nandIoOut) && $stable(nandCle) && $stable(nandAle)));

  // R11: write and read strobes never overlap
  assert_no_we_re_overlap_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  // R7: a stalled byte is held
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R8: done comes with the device released
  assert_done_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (nandCeN && !nandIoOe) ##1 !done);

  // R10: a refused request leaves the device deselected
  assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |-> (nandCeN && nandWeN));

  // R12: an accepted valid request selects the device next cycle
  assert_accept_select_R12: assert property (@(posedge clk) disable iff (!rstN)
    (reqAck && reqValid && !rangeBad) |=> (!nandCeN && !reqAck));

endmodule

// File: tb/test_nand_page_reader.sv
`timescale 1ns/1ps
module test_nand_page_reader;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid = 1'b0;
  logic        reqAck;
  logic [12:0] reqCol = '0;
  logic [17:0] reqRow = '0;
  logic [12:0] reqLen = '0;
  logic [7:0]  outData;
  logic        outValid;
  logic        outReady = 1'b1;
  logic        done, rangeErr, busyErr;
  logic        nandCeN, nandCle, nandAle, nandWeN, nandReN, nandIoOe;
  logic [7:0]  nandIoOut;
  logic [7:0]  nandIoIn = 8'h00;
  logic        nandRdy = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  nand_page_reader i_nand_page_reader (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAck(reqAck),
    .reqCol(reqCol), .reqRow(reqRow), .reqLen(reqLen),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .done(done), .rangeErr(rangeErr), .busyErr(busyErr),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandIoOut(nandIoOut),
    .nandIoOe(nandIoOe), .nandIoIn(nandIoIn), .nandRdy(nandRdy)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [7:0] pageByte(input int r, input int c);
    return 8'(c * 29 + (c >> 5) + r * 7 + 8'h5A);
  endfunction

  // ---------------- flash model ----------------
  logic [7:0] cmdLog[$];
  logic [7:0] addrLog[$];
  int weEdges = 0, rePulses = 0, violations = 0;
  int ptr = 0, curRow = 0;
  int busyRemain = 0, busyCycles = 40;

  always @(posedge nandWeN) begin
    if (nandCeN === 1'b0) begin
      weEdges++;
      if (nandCle && !nandAle) begin
        cmdLog.push_back(nandIoOut);
        if (nandIoOut == 8'h30 && addrLog.size() >= 5) begin
          int n;
          n = addrLog.size();
          ptr    = {addrLog[n-4][4:0], addrLog[n-5]};
          curRow = {addrLog[n-1][1:0], addrLog[n-2], addrLog[n-3]};
          nandIoIn   <= pageByte(curRow, ptr);
          nandRdy    <= 1'b0;
          busyRemain = busyCycles;
        end
      end else if (nandAle && !nandCle) begin
        addrLog.push_back(nandIoOut);
      end
    end
  end

  always @(posedge clk) begin
    if (busyRemain > 0) begin
      busyRemain--;
      if (busyRemain == 0) nandRdy <= 1'b1;
    end
  end

  always @(negedge nandReN) begin
    if (nandCeN === 1'b0) begin
      rePulses++;
      if (nandRdy !== 1'b1) violations++;
    end
  end

  always @(posedge nandReN) begin
    if (nandCeN === 1'b0) begin
      ptr++;
      nandIoIn <= pageByte(curRow, ptr);
    end
  end

  // ---------------- host ready pattern ----------------
  int readyMode = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    outReady = (readyMode == 0) ? 1'b1 : lfsr[0];
  end

  // ---------------- scoreboard ----------------
  logic [7:0] expQ[$];
  logic [7:0] heldByte;
  bit         stalled = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (stalled) begin
        check(outValid === 1'b1, "R7 valid held during stall", int'(outValid), 1);
        check(outData === heldByte, "R7 byte held during stall", int'(outData), int'(heldByte));
      end
      stalled = outValid && !outReady;
      heldByte = outData;
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected byte", int'(outData), -1);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(outData === e, "R6 byte order", int'(outData), int'(e));
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic issue(input int col, input int row, input int len, input bit expectData);
    if (expectData)
      for (int i = 0; i < len; i++) expQ.push_back(pageByte(row, col + i));
    @(negedge clk);
    while (!reqAck) @(negedge clk);
    reqCol = 13'(col); reqRow = 18'(row); reqLen = 13'(len);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitEvent(output int which);
    which = 0;
    while (which == 0) begin
      if (done) which = 1;
      else if (rangeErr) which = 2;
      else if (busyErr) which = 3;
      else @(negedge clk);
    end
  endtask

  task automatic readPage(input int col, input int row, input int len);
    int ev, pulses0;
    cmdLog.delete(); addrLog.delete();
    pulses0 = rePulses; violations = 0;
    issue(col, row, len, 1'b1);
    waitEvent(ev);
    check(ev == 1, "R8 done seen", ev, 1);
    check(nandCeN === 1'b1 && nandIoOe === 1'b0, "R8 released at done", int'(nandCeN), 1);
    @(negedge clk);
    check(done === 1'b0, "R8 done single cycle", int'(done), 0);
    check(expQ.size() == 0, "R6 all bytes delivered", expQ.size(), 0);
    check(rePulses - pulses0 == len, "R6 read pulse count", rePulses - pulses0, len);
    check(violations == 0, "R5 read pulse while busy", violations, 0);
    check(cmdLog.size() == 2, "R2 R4 command count", cmdLog.size(), 2);
    if (cmdLog.size() == 2) begin
      check(cmdLog[0] == 8'h00, "R2 setup command", int'(cmdLog[0]), 0);
      check(cmdLog[1] == 8'h30, "R4 confirm command", int'(cmdLog[1]), 8'h30);
    end
    check(addrLog.size() == 5, "R3 address count", addrLog.size(), 5);
    if (addrLog.size() == 5) begin
      check(addrLog[0] == 8'(col),       "R3 column low",  int'(addrLog[0]), col & 255);
      check(addrLog[1] == 8'(col >> 8),  "R3 column high", int'(addrLog[1]), col >> 8);
      check(addrLog[2] == 8'(row),       "R3 row low",     int'(addrLog[2]), row & 255);
      check(addrLog[3] == 8'(row >> 8),  "R3 row mid",     int'(addrLog[3]), (row >> 8) & 255);
      check(addrLog[4] == 8'(row >> 16), "R3 row top",     int'(addrLog[4]), row >> 16);
    end
  endtask

  task automatic rejectCase(input int col, input int len);
    int ev, we0;
    we0 = weEdges;
    issue(col, 77, len, 1'b0);
    check(nandCeN === 1'b1, "R10 device stays deselected", int'(nandCeN), 1);
    waitEvent(ev);
    check(ev == 2, "R10 range error pulse", ev, 2);
    check(weEdges == we0, "R10 no bus writes", weEdges - we0, 0);
    @(negedge clk);
    check(rangeErr === 1'b0, "R10 range error single cycle", int'(rangeErr), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  // ---------------- sequence ----------------
  initial begin
    int ev, pulses0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(nandCeN === 1 && nandWeN === 1 && nandReN === 1, "R1 strobes in reset", int'({nandCeN, nandWeN, nandReN}), 7);
    rstN = 1'b1;
    @(negedge clk);
    check(nandCle === 0 && nandAle === 0 && nandIoOe === 0, "R1 latches idle", int'({nandCle, nandAle, nandIoOe}), 0);
    check(outValid === 0 && reqAck === 1, "R1 host side idle", int'({outValid, reqAck}), 1);

    // short read from column zero, host always ready
    readyMode = 0;
    readPage(0, 18'h2A5C3, 8);
    check(reqAck === 1'b1, "R12 ack back in idle", int'(reqAck), 1);

    // read ending on the last column, top row bits set, host stalls
    readyMode = 1;
    readPage(4340, 18'h3FFFF, 12);
    readPage(4351, 18'h10203, 1);

    // long read under stalls
    readPage(1000, 18'h01234, 300);

    // refused requests
    rejectCase(4352, 1);
    rejectCase(100, 0);
    rejectCase(4000, 400);

    // stuck busy line
    busyCycles = 100000;
    pulses0 = rePulses;
    issue(0, 5, 4, 1'b0);
    waitEvent(ev);
    check(ev == 3, "R9 busy timeout pulse", ev, 3);
    check(nandCeN === 1'b1, "R9 device released on timeout", int'(nandCeN), 1);
    check(rePulses == pulses0, "R9 no read pulses", rePulses - pulses0, 0);
    @(negedge clk);
    check(busyErr === 1'b0 && reqAck === 1'b1, "R9 back to idle", int'({busyErr, reqAck}), 1);
    busyRemain = 0;
    nandRdy = 1'b1;
    busyCycles = 40;

    // clean read after recovery
    readyMode = 0;
    readPage(513, 18'h0ABCD, 5);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule